// File: doc/BRIEF.md
# Pipelined Slice-Ripple Adder

This block adds two unsigned operands and a carry-in, and it can take a new operand set on every clock edge. The carry chain is cut into equal ripple-carry slices. Each slice works in its own pipeline stage, and a register follows every stage. A sum and carry-out come out a fixed number of clocks after their operands were sampled. Once the pipe is full, one completed result leaves on every clock.

Each stage register holds several things. It holds the carry leaving the slice just computed and the sum bits produced so far. It also holds the operand bits that still wait for their slice. Every result therefore stays tied to the operand pair that produced it. A valid flag moves through the stages with the data, so the output flag marks exactly the cycles that carry a real result. The default build is a 12-bit adder made of three 4-bit slices. Slice k handles operand bits [4k+3:4k], and stage 0 handles the least significant slice.

Top module: `pipe_adder`

## Requirements
- R1: When `o_vld` is 1, `{o_cout, o_sum}` equals `i_a + i_b + i_cin` for the sampled operand set, computed at DATA_W+1 bits.
- R2: A set sampled with `i_vld`=1 on a rising edge appears at the outputs after exactly NUM_SLICES rising edges (3 by default), counting that sampling edge. `o_vld` is `i_vld` delayed by that many edges.
- R3: Operand sets given on consecutive clocks each produce their own correct result on consecutive clocks, with no gaps and no mixing of neighbours.
- R4: The carry out of each slice enters the next slice one stage later. An all-ones operand plus one therefore gives a zero sum with `o_cout`=1.
- R5: A synchronous active-high `rst` clears every valid flag. `o_vld` is 0 while reset is held and for NUM_SLICES edges after it is released, until new valid sets arrive, and sets in flight at reset never appear.
- R6: `i_cin` takes part in the addition at bit 0. With zero operands and `i_cin`=1 the sum is 1.
- R7: A cycle with `i_vld`=0 produces `o_vld`=0 in its output slot. It does not disturb the results of the valid sets on either side of it.
- R8: The largest case, all-ones plus all-ones plus carry-in 1, gives `o_sum` all ones with `o_cout`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| i_vld | input | 1 | Marks the operand set on the inputs as real |
| i_a | input | DATA_W | First operand |
| i_b | input | DATA_W | Second operand |
| i_cin | input | 1 | Carry into bit 0 |
| o_vld | output | 1 | Marks the outputs as a completed result |
| o_sum | output | DATA_W | Sum bits |
| o_cout | output | 1 | Carry out of the top bit |

## Verification
A set driven before rising edge n is due at the outputs after edge n+2, because three registers lie on its path. The bench drives and samples on falling edges. Its reference model is a three-entry shift of expected results, advanced once per falling edge. Each falling edge first compares the outputs with the entry pushed three falling edges earlier and then pushes the new set. Idle, bubble and post-reset slots therefore check that `o_vld` is low in exactly the cycle where no result is due.

// File: rtl/pipe_adder_pkg.sv
package pipe_adder_pkg;
  localparam int unsigned DEF_SLICE_W    = 4;
  localparam int unsigned DEF_NUM_SLICES = 3;

  function automatic int unsigned total_width(input int unsigned slice_w,
                                              input int unsigned n_slices);
    return slice_w * n_slices;
  endfunction
endpackage

// File: rtl/rca_slice.sv
module rca_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prop;
    assign prop       = a[i] ^ b[i];
    assign sum[i]     = prop ^ chain[i];
    assign chain[i+1] = (a[i] & b[i]) | (prop & chain[i]);
  end

  assign cout = chain[W];
endmodule

// File: rtl/add_stage.sv
module add_stage #(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned SLICE_W = 4,
  parameter int unsigned IDX     = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_sum,
  input  logic              in_c,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_a,
  output logic [DATA_W-1:0] out_b,
  output logic [DATA_W-1:0] out_sum,
  output logic              out_c
);
  localparam int unsigned LO = IDX * SLICE_W;

  logic [SLICE_W-1:0] part_sum;
  logic               part_c;

  rca_slice #(.W(SLICE_W)) u_slice (
    .a    (in_a[LO +: SLICE_W]),
    .b    (in_b[LO +: SLICE_W]),
    .cin  (in_c),
    .sum  (part_sum),
    .cout (part_c)
  );

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    out_a                   <= in_a;
    out_b                   <= in_b;
    out_sum                 <= in_sum;
    out_sum[LO +: SLICE_W]  <= part_sum;
    out_c                   <= part_c;
  end

  // R4: the slice result and its carry out form the arithmetic sum of the slice
  assert_slice_carry_R4: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ({out_c, out_sum[LO +: SLICE_W]} ==
                 ({1'b0, out_a[LO +: SLICE_W]} + {1'b0, out_b[LO +: SLICE_W]}
                  + (SLICE_W+1)'($past(in_c)))));
endmodule

// File: rtl/pipe_adder.sv
module pipe_adder
  import pipe_adder_pkg::*;
#(
  parameter int unsigned SLICE_W    = DEF_SLICE_W,
  parameter int unsigned NUM_SLICES = DEF_NUM_SLICES,
  parameter int unsigned DATA_W     = total_width(SLICE_W, NUM_SLICES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i_vld,
  input  logic [DATA_W-1:0] i_a,
  input  logic [DATA_W-1:0] i_b,
  input  logic              i_cin,
  output logic              o_vld,
  output logic [DATA_W-1:0] o_sum,
  output logic              o_cout
);
  localparam int unsigned LAT = NUM_SLICES;

  logic              s_vld [LAT+1];
  logic [DATA_W-1:0] s_a   [LAT+1];
  logic [DATA_W-1:0] s_b   [LAT+1];
  logic [DATA_W-1:0] s_sum [LAT+1];
  logic              s_c   [LAT+1];

  assign s_vld[0] = i_vld;
  assign s_a[0]   = i_a;
  assign s_b[0]   = i_b;
  assign s_sum[0] = '0;
  assign s_c[0]   = i_cin;

  for (genvar k = 0; k < LAT; k++) begin : g_stage
    add_stage #(.DATA_W(DATA_W), .SLICE_W(SLICE_W), .IDX(k)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (s_vld[k]),
      .in_a    (s_a[k]),
      .in_b    (s_b[k]),
      .in_sum  (s_sum[k]),
      .in_c    (s_c[k]),
      .out_vld (s_vld[k+1]),
      .out_a   (s_a[k+1]),
      .out_b   (s_b[k+1]),
      .out_sum (s_sum[k+1]),
      .out_c   (s_c[k+1])
    );
  end

  assign o_vld  = s_vld[LAT];
  assign o_sum  = s_sum[LAT];
  assign o_cout = s_c[LAT];

  // Reference shift for the assertions: whole-word sum, operands, valid
  logic              chk_vld [LAT];
  logic [DATA_W:0]   chk_res [LAT];
  logic [DATA_W-1:0] chk_a   [LAT];
  logic [DATA_W-1:0] chk_b   [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAT; k++) chk_vld[k] <= 1'b0;
    end else begin
      chk_vld[0] <= i_vld;
      for (int k = 1; k < LAT; k++) chk_vld[k] <= chk_vld[k-1];
    end
  end

  always_ff @(posedge clk) begin
    chk_res[0] <= {1'b0, i_a} + {1'b0, i_b} + (DATA_W+1)'(i_cin);
    chk_a[0]   <= i_a;
    chk_b[0]   <= i_b;
    for (int k = 1; k < LAT; k++) begin
      chk_res[k] <= chk_res[k-1];
      chk_a[k]   <= chk_a[k-1];
      chk_b[k]   <= chk_b[k-1];
    end
  end

  assert_sum_R1: assert property (@(posedge clk) disable iff (rst)
    o_vld |-> ({o_cout, o_sum} == chk_res[LAT-1]));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    o_vld == chk_vld[LAT-1]);

  assert_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    o_vld |-> (s_a[LAT] == chk_a[LAT-1] && s_b[LAT] == chk_b[LAT-1]));

  assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !o_vld);
endmodule

// File: tb/pipe_adder_tb.sv
module pipe_adder_tb;
  localparam int unsigned SW  = 4;
  localparam int unsigned NS  = 3;
  localparam int unsigned W   = SW * NS;
  localparam int unsigned LAT = NS;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         i_vld = 1'b0;
  logic [W-1:0] i_a = '0;
  logic [W-1:0] i_b = '0;
  logic         i_cin = 1'b0;
  logic         o_vld;
  logic [W-1:0] o_sum;
  logic         o_cout;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic         m_vld [LAT];
  logic [W:0]   m_res [LAT];
  string        m_tag [LAT];

  always #2 clk = ~clk;

  pipe_adder #(.SLICE_W(SW), .NUM_SLICES(NS)) u_dut (
    .clk(clk), .rst(rst), .i_vld(i_vld), .i_a(i_a), .i_b(i_b),
    .i_cin(i_cin), .o_vld(o_vld), .o_sum(o_sum), .o_cout(o_cout)
  );

  task automatic check(input bit ok, input string tag, input logic [W+1:0] act,
                       input logic [W+1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual {vld,cout,sum}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_model(input string tag);
    for (int k = 0; k < LAT; k++) begin
      m_vld[k] = 1'b0;
      m_res[k] = '0;
      m_tag[k] = tag;
    end
  endtask

  // One falling edge: compare the slot due now, advance the model, drive inputs
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic c, input string tag);
    @(negedge clk);
    if (m_vld[LAT-1])
      check(o_vld === 1'b1 && {o_cout, o_sum} === m_res[LAT-1], m_tag[LAT-1],
            {o_vld, o_cout, o_sum}, {1'b1, m_res[LAT-1]});
    else
      check(o_vld === 1'b0, m_tag[LAT-1], {o_vld, o_cout, o_sum}, '0);
    for (int k = LAT - 1; k > 0; k--) begin
      m_vld[k] = m_vld[k-1];
      m_res[k] = m_res[k-1];
      m_tag[k] = m_tag[k-1];
    end
    m_vld[0] = v;
    m_res[0] = {1'b0, a} + {1'b0, b} + (W+1)'(c);
    m_tag[0] = tag;
    i_vld = v; i_a = a; i_b = b; i_cin = c;
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < LAT; k++) step(1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic t_reset_state();  // R5
    @(negedge clk);
    check(o_vld === 1'b0, "R5 during reset", {o_vld, o_cout, o_sum}, '0);
    rst = 1'b0;
    clear_model("R5 after release");
    drain("R5 after release");
  endtask

  task automatic t_single_latency();  // R2, R1
    step(1'b1, 12'h123, 12'h456, 1'b0, "R2 single set");
    drain("R2 single set");
  endtask

  task automatic t_carry_ripple();  // R4, R6, R8
    step(1'b1, 12'hFFF, 12'h001, 1'b0, "R4 full ripple");
    step(1'b1, 12'h0F0, 12'h010, 1'b0, "R4 mid slice carry");
    step(1'b1, 12'h000, 12'h000, 1'b1, "R6 carry in only");
    step(1'b1, 12'hFFF, 12'h000, 1'b1, "R4 carry in ripple");
    step(1'b1, 12'hFFF, 12'hFFF, 1'b1, "R8 maximum");
    step(1'b1, 12'h800, 12'h800, 1'b0, "R1 top carry");
    drain("R4 drain");
  endtask

  task automatic t_back_to_back();  // R3, R1
    for (int n = 0; n < 60; n++)
      step(1'b1, W'($urandom), W'($urandom), 1'($urandom), "R3 back to back");
    drain("R3 drain");
  endtask

  task automatic t_bubbles();  // R7
    for (int n = 0; n < 30; n++)
      step(1'($urandom), W'($urandom), W'($urandom), 1'($urandom), "R7 bubbles");
    drain("R7 drain");
  endtask

  task automatic t_reset_midstream();  // R5
    for (int n = 0; n < 3; n++)
      step(1'b1, 12'hABC, 12'h111, 1'b1, "R5 before reset");
    @(negedge clk);
    rst = 1'b1; i_vld = 1'b0;
    @(negedge clk);
    check(o_vld === 1'b0, "R5 in-flight dropped", {o_vld, o_cout, o_sum}, '0);
    rst = 1'b0;
    clear_model("R5 flushed");
    drain("R5 flushed");
    step(1'b1, 12'h00F, 12'h001, 1'b0, "R5 resume");
    drain("R5 resume");
  endtask

  initial begin
    clear_model("R5 idle");
    t_reset_state();
    t_single_latency();
    t_carry_ripple();
    t_back_to_back();
    t_bubbles();
    t_reset_midstream();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule